// File: doc/BRIEF.md
# BCD Calendar Real-Time Clock

This block keeps wall-clock time and date as packed BCD counters: seconds, minutes, hours (24-hour), day of the week, day of the month, month, and a two-digit year that covers 2000 to 2099. A free-running slow clock, nominally 32.768 kHz, sets the pace. A fixed number of its rising edges makes one second. The slow clock is brought into the bus clock domain through a two-flop synchronizer, so the bus clock must run well above twice the slow-clock rate. The day counter rolls over after 28, 29, 30 or 31 according to the month. In February it uses the leap rule: a year divisible by four has 29 days, and the year field only spans 2000 to 2099.

Software reaches the block over a simple byte-wide register bus. Three control registers set the counter enable and the hour-format flag, hold an alarm-enable flag, and run the stop handshake. To set the time, software does the following:
1. Write the hold-request bit.
2. Poll until the hold-acknowledge bit reads set. This takes two slow-clock edges.
3. Write the seven load registers.
4. Clear the hold register. Counting then resumes from the loaded values.

The live counters are read at a separate set of addresses. All fields change in the same bus-clock cycle, so a read never returns a half-updated field.

Top module: `cal_rtc_top`

## Requirements
- R1: After reset, the registers read as follows:
  - Control register 0 (offset 0x00) reads 0x00, so the counter enable is clear.
  - Control register 2 (offset 0x08) reads 0x03: hold requested and acknowledged.
  - The live fields read: seconds 0x00, minutes 0x00, hours 0x00, weekday 0x06, day 0x01, month 0x01, year 0x00.
- R2: Seconds and minutes count in BCD, carrying from ones to tens after 9 and wrapping 0x59 to 0x00. A seconds wrap advances the minutes.
- R3: Hours wrap 0x23 to 0x00 and advance the day. The weekday field (0 = Sunday … 6 = Saturday) steps with the day and wraps 6 to 0.
- R4: Day rolls to 0x01 after 0x30 in months 0x04, 0x06, 0x09 and 0x11, and after 0x31 in the other months except February. The month then advances.
- R5: In February the day rolls after 0x29 when the year is divisible by four (0x00 included), and after 0x28 otherwise.
- R6: Month wraps 0x12 to 0x01 and advances the year. The year wraps 0x99 to 0x00.
- R7: Control register 2 has two bits:
  - Bit 0 is the hold request, read/write. It stops counting as soon as it is set.
  - Bit 1 is the read-only acknowledge. It reads 0 just after the request is set and goes to 1 after two synchronized slow-clock rising edges. It clears within one cycle once the request is cleared.
  - While either bit is set, the counters do not advance.
- R8: Writes to the load addresses change the live fields only while the acknowledge bit is set; they take effect at that time, and are ignored while counting. The load addresses are 0x14 seconds, 0x18 minutes, 0x1C hours, 0x20 weekday, 0x24 day, 0x28 month, 0x2C year.
- R9: With control register 0 bit 7 (counter enable) clear, the fields do not advance even when the hold is released.
- R10: Control register 0 bit 5 (hour-format flag) and control register 1 (offset 0x04) bit 4 (alarm enable) store the written value and read it back. All other bits of these registers read 0.
- R11: The live fields read at 0x4C seconds, 0x50 minutes, 0x54 hours, 0x58 weekday, 0x5C day, 0x60 month, 0x64 year. The load addresses read as 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Active-low synchronous reset |
| slowClk | input | 1 | 32.768 kHz time base, asynchronous to clk |
| busWe | input | 1 | Write strobe, one cycle per write |
| busAddr | input | ADDR_W | Byte address of the register |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data for busAddr, combinational |

## Verification
The embedded assertions watch the following on every cycle:
- The stop handshake:
  - The acknowledge is never set in the cycle right after a fresh request.
  - The acknowledge only rises while a request was present.
  - The acknowledge drops right after release.
- The datapath stays frozen when there is neither a load nor a second tick.
- The 59-to-00 seconds wrap and the Saturday-to-Sunday weekday wrap at a midnight rollover.

Only the bench's scenarios show calendar-level outcomes, because each needs a loaded date followed by a real one-second rollover:
- month lengths and leap years, including year 00;
- the December and year-99 wrap;
- writes ignored while counting;
- the effect of a clear enable bit.

// File: rtl/cal_rtc_pkg.sv
package cal_rtc_pkg;

  localparam int NUM_FIELDS = 7;
  localparam int ADDR_CTL0 = 'h00;
  localparam int ADDR_CTL1 = 'h04;
  localparam int ADDR_CTL2 = 'h08;
  localparam int LOAD_BASE = 'h14;
  localparam int RDBK_BASE = 'h4C;

  typedef enum logic [2:0] {
    F_SEC  = 3'd0,
    F_MIN  = 3'd1,
    F_HOUR = 3'd2,
    F_WDAY = 3'd3,
    F_DAY  = 3'd4,
    F_MON  = 3'd5,
    F_YEAR = 3'd6
  } fieldIdx_e;

  typedef struct packed {
    logic      secInc;
    logic      loadEn;
    fieldIdx_e loadField;
    logic [7:0] loadData;
  } dpStrobe_t;

  function automatic logic [7:0] bcdInc(input logic [7:0] v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'h0};
    return {v[7:4], v[3:0] + 4'd1};
  endfunction

  function automatic logic [7:0] lastDay(input logic [7:0] mon, input logic [7:0] yr);
    logic [7:0] yBin;
    yBin = 8'(v10(yr[7:4])) + {4'h0, yr[3:0]};
    case (mon)
      8'h02:                      return (yBin[1:0] == 2'b00) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

  function automatic logic [7:0] v10(input logic [3:0] d);
    return {d, 3'b000} + {3'b000, d, 1'b0};
  endfunction

endpackage

// File: rtl/cal_rtc_ctrl.sv
module cal_rtc_ctrl
  import cal_rtc_pkg::*;
#(
  parameter int TICKS_PER_SEC = 32768,
  parameter int ADDR_W        = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              slowClk,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [7:0]        busWdata,
  output dpStrobe_t         strobe,
  output logic [7:0]        ctl0Rd,
  output logic [7:0]        ctl1Rd,
  output logic [7:0]        ctl2Rd
);

  localparam int PRESC_W = (TICKS_PER_SEC > 1) ? $clog2(TICKS_PER_SEC) : 1;

  logic [2:0] slowSync;
  logic       slowEdge;
  logic       clkEnable, mode24, alarmEn, holdReq;
  logic [1:0] ackPipe;
  logic       holdAck;
  logic       running;
  logic [PRESC_W-1:0] prescCnt;
  logic [ADDR_W-1:0]  ldOff;
  logic       ldHit;

  // two synchronizer flops followed by one edge-history flop
  always_ff @(posedge clk) begin
    if (!rstN) slowSync <= '0;
    else       slowSync <= {slowSync[1:0], slowClk};
  end
  assign slowEdge = slowSync[1] & ~slowSync[2];

  assign holdAck = ackPipe[1];
  assign running = clkEnable & ~holdReq & ~holdAck;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      clkEnable <= 1'b0;
      mode24    <= 1'b0;
      alarmEn   <= 1'b0;
      holdReq   <= 1'b1;
      ackPipe   <= 2'b11;
      prescCnt  <= '0;
    end else begin
      if (busWe && busAddr == ADDR_W'(ADDR_CTL0)) begin
        clkEnable <= busWdata[7];
        mode24    <= busWdata[5];
      end
      if (busWe && busAddr == ADDR_W'(ADDR_CTL1)) alarmEn <= busWdata[4];
      if (busWe && busAddr == ADDR_W'(ADDR_CTL2)) holdReq <= busWdata[0];
      if (!holdReq)      ackPipe <= 2'b00;
      else if (slowEdge) ackPipe <= {ackPipe[0], 1'b1};
      if (slowEdge && running)
        prescCnt <= (prescCnt == PRESC_W'(TICKS_PER_SEC - 1)) ? '0 : prescCnt + 1'b1;
    end
  end

  assign ldOff = busAddr - ADDR_W'(LOAD_BASE);
  assign ldHit = (busAddr >= ADDR_W'(LOAD_BASE)) && (ldOff[1:0] == 2'b00) &&
                 (ldOff[ADDR_W-1:2] < (ADDR_W-2)'(NUM_FIELDS));

  always_comb begin
    strobe.secInc    = slowEdge & running & (prescCnt == PRESC_W'(TICKS_PER_SEC - 1));
    strobe.loadEn    = busWe & ldHit & holdAck;
    strobe.loadField = fieldIdx_e'(ldOff[4:2]);
    strobe.loadData  = busWdata;
  end

  assign ctl0Rd = {clkEnable, 1'b0, mode24, 5'b0};
  assign ctl1Rd = {3'b0, alarmEn, 4'b0};
  assign ctl2Rd = {6'b0, holdAck, holdReq};

  // R7: a fresh request is never acknowledged in the next cycle
  a_r7_ack_not_immediate: assert property (@(posedge clk) disable iff (!rstN)
    $rose(holdReq) |=> !holdAck);
  // R7: acknowledge only rises out of a pending request
  a_r7_ack_follows_req: assert property (@(posedge clk) disable iff (!rstN)
    $rose(holdAck) |-> $past(holdReq));
  // R7: releasing the request drops the acknowledge
  a_r7_ack_clears: assert property (@(posedge clk) disable iff (!rstN)
    $fell(holdReq) |=> !holdAck);

endmodule

// File: rtl/cal_rtc_datapath.sv
module cal_rtc_datapath
  import cal_rtc_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  dpStrobe_t strobe,
  output logic [NUM_FIELDS-1:0][7:0] timeQ
);

  logic [7:0] sec, min, hour, wday, day, mon, year;
  logic secWrap, minWrap, hourWrap, dayWrap, monWrap;

  assign secWrap  = (sec  == 8'h59);
  assign minWrap  = (min  == 8'h59);
  assign hourWrap = (hour == 8'h23);
  assign dayWrap  = (day  == lastDay(mon, year));
  assign monWrap  = (mon  == 8'h12);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sec <= 8'h00; min <= 8'h00; hour <= 8'h00; wday <= 8'h06;
      day <= 8'h01; mon <= 8'h01; year <= 8'h00;
    end else if (strobe.loadEn) begin
      case (strobe.loadField)
        F_SEC:   sec  <= strobe.loadData;
        F_MIN:   min  <= strobe.loadData;
        F_HOUR:  hour <= strobe.loadData;
        F_WDAY:  wday <= strobe.loadData;
        F_DAY:   day  <= strobe.loadData;
        F_MON:   mon  <= strobe.loadData;
        F_YEAR:  year <= strobe.loadData;
        default: ;
      endcase
    end else if (strobe.secInc) begin
      sec <= secWrap ? 8'h00 : bcdInc(sec);
      if (secWrap) begin
        min <= minWrap ? 8'h00 : bcdInc(min);
        if (minWrap) begin
          hour <= hourWrap ? 8'h00 : bcdInc(hour);
          if (hourWrap) begin
            wday <= (wday >= 8'h06) ? 8'h00 : wday + 8'h01;
            day  <= dayWrap ? 8'h01 : bcdInc(day);
            if (dayWrap) begin
              mon <= monWrap ? 8'h01 : bcdInc(mon);
              if (monWrap) year <= (year == 8'h99) ? 8'h00 : bcdInc(year);
            end
          end
        end
      end
    end
  end

  assign timeQ = {year, mon, day, wday, hour, min, sec};

  // R2: a tick at 59 seconds returns seconds to 00
  a_r2_sec_wrap: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.secInc && !strobe.loadEn && sec == 8'h59) |=> (sec == 8'h00));
  // R3: Saturday midnight rollover lands on Sunday
  a_r3_wday_wrap: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.secInc && !strobe.loadEn && sec == 8'h59 && min == 8'h59 &&
     hour == 8'h23 && wday == 8'h06) |=> (wday == 8'h00));
  // R7: no tick and no load means the time is frozen
  a_r7_frozen_when_idle: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.secInc && !strobe.loadEn) |=> $stable(timeQ));

endmodule

// File: rtl/cal_rtc_top.sv
module cal_rtc_top
  import cal_rtc_pkg::*;
#(
  parameter int TICKS_PER_SEC = 32768,
  parameter int ADDR_W        = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              slowClk,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [7:0]        busWdata,
  output logic [7:0]        busRdata
);

  dpStrobe_t strobe;
  logic [7:0] ctl0Rd, ctl1Rd, ctl2Rd;
  logic [NUM_FIELDS-1:0][7:0] timeQ;
  logic [ADDR_W-1:0] rbOff;
  logic rbHit;

  cal_rtc_ctrl #(.TICKS_PER_SEC(TICKS_PER_SEC), .ADDR_W(ADDR_W)) uCtrl (
    .clk(clk), .rstN(rstN), .slowClk(slowClk), .busWe(busWe),
    .busAddr(busAddr), .busWdata(busWdata), .strobe(strobe),
    .ctl0Rd(ctl0Rd), .ctl1Rd(ctl1Rd), .ctl2Rd(ctl2Rd)
  );

  cal_rtc_datapath uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .timeQ(timeQ)
  );

  assign rbOff = busAddr - ADDR_W'(RDBK_BASE);
  assign rbHit = (busAddr >= ADDR_W'(RDBK_BASE)) && (rbOff[1:0] == 2'b00) &&
                 (rbOff[ADDR_W-1:2] < (ADDR_W-2)'(NUM_FIELDS));

  always_comb begin
    busRdata = 8'h00;
    if (busAddr == ADDR_W'(ADDR_CTL0))      busRdata = ctl0Rd;
    else if (busAddr == ADDR_W'(ADDR_CTL1)) busRdata = ctl1Rd;
    else if (busAddr == ADDR_W'(ADDR_CTL2)) busRdata = ctl2Rd;
    else if (rbHit)                         busRdata = timeQ[rbOff[4:2]];
  end

endmodule

// File: tb/sim_cal_rtc_top.sv
module sim_cal_rtc_top;

  localparam int TPS = 4;
  localparam logic [6:0] A_CTL0 = 7'h00, A_CTL1 = 7'h04, A_CTL2 = 7'h08;
  localparam logic [6:0] A_LD = 7'h14, A_RB = 7'h4C;

  logic clk = 1'b0, slowClk = 1'b0, rstN = 1'b0;
  logic busWe = 1'b0;
  logic [6:0] busAddr = '0;
  logic [7:0] busWdata = '0;
  logic [7:0] busRdata;

  always #4 clk = ~clk;
  always #32 slowClk = ~slowClk;

  cal_rtc_top #(.TICKS_PER_SEC(TPS), .ADDR_W(7)) u0 (
    .clk(clk), .rstN(rstN), .slowClk(slowClk), .busWe(busWe),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata)
  );

  typedef struct { logic [6:0] addr; logic [7:0] exp; string tag; } item_t;
  item_t q[$];
  int nChecks = 0, nFails = 0;
  bit finished = 1'b0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: pops expected items and compares once the addressed value is settled
  initial forever begin
    @(posedge clk); #2;
    if (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      check(busRdata == it.exp, it.tag, busRdata, it.exp);
    end
  end

  task automatic wr(input logic [6:0] a, input logic [7:0] d);
    @(negedge clk); busAddr = a; busWdata = d; busWe = 1'b1;
    @(negedge clk); busWe = 1'b0;
  endtask

  task automatic expectReg(input logic [6:0] a, input logic [7:0] e, input string tag);
    item_t it;
    @(negedge clk); busAddr = a;
    it.addr = a; it.exp = e; it.tag = tag;
    q.push_back(it);
    @(negedge clk);
  endtask

  task automatic peek(input logic [6:0] a, output logic [7:0] v);
    @(negedge clk); busAddr = a; #1; v = busRdata;
  endtask

  task automatic holdAndWait(input string tag);
    logic [7:0] v;
    int n;
    wr(A_CTL2, 8'h01);
    n = 0;
    do begin peek(A_CTL2, v); n++; end while (!v[1] && n < 60);
    check(v[1] == 1'b1, tag, v, 8'h03);
  endtask

  task automatic loadAll(input logic [7:0] f[7]);
    for (int i = 0; i < 7; i++) wr(A_LD + 7'(4 * i), f[i]);
  endtask

  task automatic expectAll(input logic [7:0] f[7], input string tag);
    for (int i = 0; i < 7; i++) expectReg(A_RB + 7'(4 * i), f[i], tag);
  endtask

  // load fields (sec..year) with sec=59, run one second, hold, compare
  task automatic rollTest(input logic [7:0] ld[7], input logic [7:0] ex[7], input string tag);
    logic [7:0] v;
    int n;
    holdAndWait(tag);
    loadAll(ld);
    wr(A_CTL2, 8'h00);
    n = 0;
    do begin peek(A_RB, v); n++; end while (v != 8'h00 && n < 400);
    check(v == 8'h00, {tag, " rollover seen"}, v, 8'h00);
    holdAndWait(tag);
    expectAll(ex, tag);
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      check(1'b0, "watchdog", 0, 1);
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    int n;
    repeat (4) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    expectReg(A_CTL0, 8'h00, "R1 ctl0");
    expectReg(A_CTL2, 8'h03, "R1 ctl2");
    expectAll('{8'h00, 8'h00, 8'h00, 8'h06, 8'h01, 8'h01, 8'h00}, "R1 fields");
    // R11 load addresses read zero
    expectReg(A_LD, 8'h00, "R11 load addr reads 0");

    // R10 flag storage
    wr(A_CTL1, 8'hFF); expectReg(A_CTL1, 8'h10, "R10 alarm enable set");
    wr(A_CTL1, 8'h00); expectReg(A_CTL1, 8'h00, "R10 alarm enable clear");
    wr(A_CTL0, 8'h20); expectReg(A_CTL0, 8'h20, "R10 hour flag");

    // R8 load while held (reset leaves hold acknowledged)
    loadAll('{8'h12, 8'h34, 8'h05, 8'h02, 8'h17, 8'h08, 8'h21});
    expectAll('{8'h12, 8'h34, 8'h05, 8'h02, 8'h17, 8'h08, 8'h21}, "R8 load while held");

    // R9 enable clear: released but not counting
    wr(A_CTL2, 8'h00);
    repeat (300) @(negedge clk);
    expectReg(A_CTL2, 8'h00, "R9 released");
    expectReg(A_RB, 8'h12, "R9 no count while disabled");

    // R7 handshake timing
    wr(A_CTL0, 8'hA0);
    wr(A_CTL2, 8'h01);
    expectReg(A_CTL2, 8'h01, "R7 ack not yet set");
    n = 0;
    do begin peek(A_CTL2, v); n++; end while (!v[1] && n < 60);
    check(v == 8'h03, "R7 ack set", v, 8'h03);
    check(n >= 4 && n <= 30, "R7 ack delay cycles", n, 10);
    wr(A_CTL2, 8'h00);
    expectReg(A_CTL2, 8'h00, "R7 ack cleared on release");

    // R8 writes ignored while counting
    holdAndWait("R8 hold");
    wr(A_LD + 7'h18, 8'h24);
    wr(A_CTL2, 8'h00);
    repeat (3) @(negedge clk);
    wr(A_LD + 7'h18, 8'h77);
    holdAndWait("R8 hold again");
    expectReg(A_RB + 7'h18, 8'h24, "R8 load ignored while counting");

    // R2 BCD carry of minutes 09 -> 10
    rollTest('{8'h59, 8'h09, 8'h10, 8'h03, 8'h15, 8'h06, 8'h24},
             '{8'h00, 8'h10, 8'h10, 8'h03, 8'h15, 8'h06, 8'h24}, "R2 minute carry");
    // R3 + R5 leap year, weekday 6 -> 0
    rollTest('{8'h59, 8'h59, 8'h23, 8'h06, 8'h28, 8'h02, 8'h24},
             '{8'h00, 8'h00, 8'h00, 8'h00, 8'h29, 8'h02, 8'h24}, "R3 R5 leap Feb 28");
    // R5 common year
    rollTest('{8'h59, 8'h59, 8'h23, 8'h02, 8'h28, 8'h02, 8'h23},
             '{8'h00, 8'h00, 8'h00, 8'h03, 8'h01, 8'h03, 8'h23}, "R5 common Feb 28");
    // R5 year 00 is leap
    rollTest('{8'h59, 8'h59, 8'h23, 8'h01, 8'h28, 8'h02, 8'h00},
             '{8'h00, 8'h00, 8'h00, 8'h02, 8'h29, 8'h02, 8'h00}, "R5 year 00 leap");
    // R4 thirty-day month
    rollTest('{8'h59, 8'h59, 8'h23, 8'h02, 8'h30, 8'h04, 8'h24},
             '{8'h00, 8'h00, 8'h00, 8'h03, 8'h01, 8'h05, 8'h24}, "R4 April 30");
    // R4 thirty-one-day month does not wrap at 30
    rollTest('{8'h59, 8'h59, 8'h23, 8'h04, 8'h30, 8'h05, 8'h24},
             '{8'h00, 8'h00, 8'h00, 8'h05, 8'h31, 8'h05, 8'h24}, "R4 May 30");
    // R6 year wrap
    rollTest('{8'h59, 8'h59, 8'h23, 8'h04, 8'h31, 8'h12, 8'h99},
             '{8'h00, 8'h00, 8'h00, 8'h05, 8'h01, 8'h01, 8'h00}, "R6 Dec 31 99");

    while (q.size() > 0) @(negedge clk);
    repeat (2) @(negedge clk);
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

endmodule